// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects an internal clocked request bus to an external asynchronous static RAM of 128K bytes. The RAM has three active-low strobes: chip select, output enable and write enable. Its data bus is bidirectional and shared. A client offers one single-beat read or write at a time through a valid/ready handshake. The controller then sequences the strobes with cycle counters, so that the RAM's write pulse, data setup, access time and bus turnaround rules hold at the clock rate in use. It reports completion with a one-cycle response pulse that also carries read data.

The controller owns the address lines, the three strobes, and the output value and output enable of its half of the data bus. The pad-level tristate buffer is outside the block. Writes are always issued with output enable high, so the RAM never drives the bus while the controller does. Read data is registered at the end of a configurable number of wait cycles. Every access ends with configurable turnaround cycles in which all strobes are inactive, before the next request is taken. Timing is given in whole cycles by the parameters `RD_WAIT`, `WR_PULSE` and `TURN`.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the outputs are: `mem_cs_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. Bit `req_write`=1 means write and 0 means read. `req_ready` is 0 from the next cycle until the access and its turnaround are over. A `req_valid` seen while `req_ready` is 0 starts nothing.
- R3: A write holds `mem_cs_n`=0 with `mem_we_n`=1 for one cycle. It then holds `mem_we_n`=0 for exactly `WR_PULSE` cycles. `mem_oe_n` stays 1 for the whole write.
- R4: `mem_dq_oe` is 1 in exactly the cycles where `mem_we_n` is 0. In those cycles `mem_dq_out` carries the request's write data. The driver is released in the same cycle in which `mem_we_n` rises.
- R5: `mem_addr` equals the accepted request address and does not change during any cycle in which `mem_cs_n` is 0.
- R6: A read holds `mem_cs_n`=0 and `mem_oe_n`=0, with `mem_we_n`=1, for exactly `RD_WAIT` cycles. The value on `mem_dq_in` at the clock edge that ends the last of those cycles is returned on `rsp_rdata`.
- R7: `rsp_valid` is a one-cycle pulse in the first cycle after the strobes of an access return high, for reads and for writes alike. `rsp_rdata` is valid in that cycle.
- R8: After every access, all strobes stay inactive for `TURN` cycles before `req_ready` returns to 1. A read that follows a write, or a write that follows a read, is therefore separated by at least `TURN` idle cycles.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, so the controller and the RAM never drive the data bus together.
- R10: The whole 17-bit address range is reachable, including addresses 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 17 | RAM address lines |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Enables the controller's data bus driver |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
Writes to random addresses are read back later. This shows whether data reaches the right location, rather than only matching whatever was last driven. Back-to-back write-then-read pairs to the same address stress the turnaround, and show whether a read can start before the previous write's recovery cycles are over. The addresses 0x00000 and 0x1FFFF separate a full-width address path from a truncated one. Reads of locations that were never written return an address-dependent pattern, which shows whether read data comes from the addressed location. The bench's RAM model also measures pulse widths, data setup time and address stability in simulated time, and it checks on every cycle that the two data drivers are never on together.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types for the asynchronous SRAM controller.
package sram_ctrl_pkg;

    // Phases of one access; IDLE must stay the zero code.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_WPULSE = 3'd2,
        ST_RWAIT  = 3'd3,
        ST_RECOV  = 3'd4
    } seq_state_t;

    // Larger of two integers, used to size the shared phase counter.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_hold_reg.sv
// Module: sram_hold_reg
// Loadable register with synchronous active-low reset to zero.
// Assumes: load is a single-cycle strobe from the sequencer or request side.
module sram_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d whenever load is high, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
// Module: sram_seq_fsm
// Access sequencer: walks IDLE -> (SETUP -> WPULSE | RWAIT) -> RECOV -> IDLE.
// One down-counter times the write pulse, the read wait and the turnaround.
// Assumes: RD_WAIT, WR_PULSE and TURN are all at least 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_WAIT  = 2,
    parameter int WR_PULSE = 1,
    parameter int TURN     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    output seq_state_t state,
    output logic       cap_en,
    output logic       done
);

    localparam int CNT_MAX = imax(imax(RD_WAIT, WR_PULSE), TURN);
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN - 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State and phase counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= is_write ? ST_SETUP : ST_RWAIT;
                        cnt   <= RD_LOAD;
                    end
                end
                ST_SETUP: begin
                    state <= ST_WPULSE;
                    cnt   <= WR_LOAD;
                end
                ST_WPULSE, ST_RWAIT: begin
                    if (cnt_zero) begin
                        state <= ST_RECOV;
                        cnt   <= TURN_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_RECOV: begin
                    if (cnt_zero) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture strobe for the edge that ends the last read wait cycle.
    always_comb cap_en = (state == ST_RWAIT) && cnt_zero;

    // Completion flag in the first turnaround cycle.
    always_comb done = (state == ST_RECOV) && (cnt == TURN_LOAD);

endmodule

// File: rtl/sram_strobe_dec.sv
// Module: sram_strobe_dec
// Maps the sequencer phase to the RAM strobes, the data driver enable and
// request readiness. Every output depends only on the registered phase.
// Assumes: writes keep output enable high, so the driver and the RAM never overlap.
module sram_strobe_dec
    import sram_ctrl_pkg::*;
(
    input  seq_state_t state,
    output logic       cs_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe,
    output logic       ready
);

    // Decode the phase into the pin levels.
    always_comb begin
        cs_n  = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        ready = 1'b0;
        case (state)
            ST_IDLE:   ready = 1'b1;
            ST_SETUP:  cs_n  = 1'b0;
            ST_WPULSE: begin
                cs_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_RWAIT: begin
                cs_n = 1'b0;
                oe_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_ctrl.sv
// Module: sram_ctrl (top)
// Single-beat request front end for an asynchronous static RAM. It latches the
// request, sequences the strobes through sram_seq_fsm, decodes the pins in
// sram_strobe_dec and registers the read data.
// Assumes: RD_WAIT * clock period covers the access time plus input margin;
// WR_PULSE * period covers both the write pulse and the data setup time.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int RD_WAIT  = 2,
    parameter int WR_PULSE = 1,
    parameter int TURN     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    seq_state_t state;
    logic       accept;
    logic       cap_en;

    // A request is taken only when the sequencer is idle.
    always_comb accept = req_valid && req_ready;

    sram_seq_fsm #(
        .RD_WAIT (RD_WAIT),
        .WR_PULSE(WR_PULSE),
        .TURN    (TURN)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .is_write(req_write),
        .state   (state),
        .cap_en  (cap_en),
        .done    (rsp_valid)
    );

    sram_strobe_dec u_dec (
        .state(state),
        .cs_n (mem_cs_n),
        .oe_n (mem_oe_n),
        .we_n (mem_we_n),
        .dq_oe(mem_dq_oe),
        .ready(req_ready)
    );

    sram_hold_reg #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .d(req_addr), .q(mem_addr)
    );

    sram_hold_reg #(.W(DATA_W)) u_wdata (
        .clk(clk), .rst_n(rst_n), .load(accept && req_write), .d(req_wdata), .q(mem_dq_out)
    );

    sram_hold_reg #(.W(DATA_W)) u_rdata (
        .clk(clk), .rst_n(rst_n), .load(cap_en), .d(mem_dq_in), .q(rsp_rdata)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Module: sram_ctrl_chk
// Protocol checker bound to sram_ctrl; observes only its ports.
module sram_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_CS_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_cs_n && mem_we_n)); // R3

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R3

    AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe); // R4

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_cs_n && $past(!mem_cs_n))); // R7

    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && mem_we_n && mem_oe_n)); // R8

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n)); // R9

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
// Bench: queue-based cycle reference model plus a behavioural timed RAM model.
`timescale 1ns/1ps
module tb_sram_ctrl;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RDW = 2;
    localparam int WRP = 1;
    localparam int TRN = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RDW), .WR_PULSE(WRP), .TURN(TRN)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // One check; prints FAIL with requirement, actual and expected on mismatch.
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Contents of a never-written location, independent of the design.
    function automatic logic [DW-1:0] fill(input int a);
        return DW'(a ^ (a >> 8) ^ 8'h5A);
    endfunction

    // ---------------- behavioural RAM with timing checks ----------------
    logic [DW-1:0] ram [int];
    logic ram_drive, wr_act, rd_act;
    realtime wr_t0, rd_t0, data_t, cs_fall_t;
    logic [DW-1:0] data_v;

    assign ram_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign wr_act    = !mem_cs_n && !mem_we_n;
    assign rd_act    = ram_drive;
    assign mem_dq_in = ram_drive ? (ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : fill(int'(mem_addr))) : 8'h00;

    always @(negedge mem_cs_n) cs_fall_t = $realtime;
    always @(mem_addr) if (rst_n && !mem_cs_n && $realtime != cs_fall_t)
        chk(1'b0, "R5 address moved while selected", longint'(mem_addr), 0);
    always @(posedge mem_dq_oe or mem_dq_out) if (mem_dq_oe) begin
        data_v = mem_dq_out; data_t = $realtime;
    end
    always @(posedge wr_act) begin
        wr_t0 = $realtime;
        chk(mem_oe_n, "R3 output enable high during write", longint'(mem_oe_n), 1);
    end
    always @(negedge wr_act) if (rst_n) begin
        chk($realtime - wr_t0 >= 7.0, "R3 write pulse >= 7ns", longint'($realtime - wr_t0), 7);
        chk($realtime - data_t >= 5.0, "R4 data setup >= 5ns", longint'($realtime - data_t), 5);
        ram[int'(mem_addr)] = data_v;
    end
    always @(posedge rd_act) rd_t0 = $realtime;
    always @(negedge rd_act) if (rst_n)
        chk($realtime - rd_t0 >= 10.0, "R6 read window >= 10ns", longint'($realtime - rd_t0), 10);
    always @(negedge clk) if (rst_n)
        chk(!(mem_dq_oe && ram_drive), "R9 bus contention", {mem_dq_oe, ram_drive}, 0);

    // ---------------- cycle reference model ----------------
    typedef struct {
        bit cs_n, oe_n, we_n, dq_oe, rdy, rv, chk_a, chk_d, rd;
        int tag;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } exp_t;

    exp_t q[$];
    logic [DW-1:0] shadow [int];

    function automatic exp_t mk(bit cs_n, bit oe_n, bit we_n, bit dq_oe, bit rv, int tag);
        exp_t e;
        e.cs_n = cs_n; e.oe_n = oe_n; e.we_n = we_n; e.dq_oe = dq_oe;
        e.rdy = 1'b0; e.rv = rv; e.tag = tag; e.chk_a = 0; e.chk_d = 0; e.rd = 0;
        e.a = '0; e.d = '0;
        return e;
    endfunction

    // Push the expected cycles that follow an accepted request.
    task automatic push_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        if (w) begin
            e = mk(0, 1, 1, 0, 0, 3); e.chk_a = 1; e.a = a; q.push_back(e);          // R3 setup
            for (int i = 0; i < WRP; i++) begin
                e = mk(0, 1, 0, 1, 0, 4); e.chk_a = 1; e.a = a; e.chk_d = 1; e.d = d; // R4
                q.push_back(e);
            end
            shadow[int'(a)] = d;
        end else begin
            for (int i = 0; i < RDW; i++) begin
                e = mk(0, 0, 1, 0, 0, 6); e.chk_a = 1; e.a = a; q.push_back(e);      // R6
            end
        end
        for (int i = 0; i < TRN; i++) begin
            e = mk(1, 1, 1, 0, i == 0, 8);                                          // R8, R7
            if (i == 0 && !w) begin
                e.rd = 1;
                e.d = shadow.exists(int'(a)) ? shadow[int'(a)] : fill(int'(a));
            end
            q.push_back(e);
        end
    endtask

    // Compare at the falling edge, note acceptance, then pass the rising edge.
    task automatic step();
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else begin e = mk(1, 1, 1, 0, 0, 1); e.rdy = 1'b1; end                       // R1 idle
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == {e.cs_n, e.oe_n, e.we_n, e.dq_oe},
            $sformatf("R%0d strobes", e.tag), {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe},
            {e.cs_n, e.oe_n, e.we_n, e.dq_oe});
        chk(req_ready == e.rdy, "R2 ready", req_ready, e.rdy);
        chk(rsp_valid == e.rv, "R7 response pulse", rsp_valid, e.rv);
        if (e.chk_a) chk(mem_addr == e.a, "R5 address", mem_addr, e.a);
        if (e.chk_d) chk(mem_dq_out == e.d, "R4 write data", mem_dq_out, e.d);
        if (e.rd)    chk(rsp_rdata == e.d, "R6 read data", rsp_rdata, e.d);
        if (req_valid && e.rdy) push_req(req_write, req_addr, req_wdata);
        @(posedge clk);
        #1;
    endtask

    // Offer one request and hold it until taken.
    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit taken;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        taken = 0;
        while (!taken) begin
            taken = (q.size() == 0);
            step();
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] addrs [24];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 reset state", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(3);                                    // R1 idle, R2 valid low ignored

        // R10: address extremes, write then read back
        do_req(1, 17'h00000, 8'hA5);
        do_req(1, 17'h1FFFF, 8'h3C);
        do_req(0, 17'h00000, 8'h00);
        do_req(0, 17'h1FFFF, 8'h00);
        idle(2);

        // R6: reads of never-written locations return the fill pattern
        do_req(0, 17'h0ABCD, 8'h00);
        do_req(0, 17'h10000, 8'h00);

        // R3 R4 R5: random writes, then random-order readback
        for (int i = 0; i < 24; i++) begin
            addrs[i] = AW'($urandom);
            do_req(1, addrs[i], DW'($urandom));
            if (i % 5 == 0) idle(1);
        end
        for (int i = 23; i >= 0; i--) do_req(0, addrs[i], 8'h00);

        // R8: back-to-back write-then-read turnaround, also read-then-write
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a = AW'($urandom);
            do_req(1, a, DW'(i * 37 + 1));
            do_req(0, a, 8'h00);
            do_req(1, a, DW'(~(i * 37 + 1)));
        end
        idle(6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule